// File: doc/BRIEF.md
# PHY Bring-up Configuration Sequencer

This block brings a USB3/PCIe combo PHY into USB3 operation after a single start request. It first holds the PHY reset for a timed window (one microsecond at the default 50 MHz clock), then releases it and sets the two-bit mode switch in a local control register to USB3. It then walks a short, fixed table of masked updates. Each table entry is applied as a read followed by a write of the merged word, through an external control-register bus master.

After the last table entry, the block adjusts the transmit boost field and the two loss-of-signal fields in local configuration registers, and raises `done_o`. A bus error on any transaction ends the run at once with `done_o` and `err_o` both set. A stop request puts the PHY back into reset and abandons the run. A new start from the idle or finished state runs the whole sequence again.

Top module: `brup_phy_cfg_seq`

## Requirements
- R1: After rst_ni, phy_rst_o is 1, cr_req_o, done_o and err_o are 0, and ctl0_o, cfg1_o and cfg2_o hold their reset parameter values.
- R2: A start accepted in the idle or finished state keeps phy_rst_o at 1 for exactly RST_CYCLES clock cycles after the accepting edge and then drives it to 0. No bus request is made while phy_rst_o is 1.
- R3: After the reset window and before the first bus request, ctl0_o bits 6:5 become 2'b11 and all its other bits keep their value.
- R4: Each table step is a read (cr_we_o=0) of the step address, followed by a write (cr_we_o=1) to the same address of (read data & ~mask) | value. Value bits outside the mask are therefore also set.
- R5: The steps run strictly in this order, as address/mask/value in hex: 102D/0080/0080, 1010/0FF0/0014, 1006/0FC0/0B80, 1002/7FFF/4B7F, 0030/00F0/0080. A full run makes exactly 10 transactions.
- R6: A request holds cr_req_o, cr_addr_o, cr_we_o and cr_wdata_o stable until the cycle in which cr_ack_i or cr_err_i is seen. Only one transaction is outstanding.
- R7: After the last write, cfg2_o bits 20:18 become 4. Then cfg1_o bits 23:21 become 4 and bits 20:16 become 9. All other bits of both registers are kept.
- R8: A run without error ends with done_o=1, err_o=0 and no further request, and holds that state until a start or a stop.
- R9: cr_err_i on any transaction ends the run on that edge: done_o=1 and err_o=1, no further request, and cfg1_o and cfg2_o are left unchanged.
- R10: stop_i in any state drives phy_rst_o to 1 and cr_req_o, done_o and err_o to 0 on the next cycle, and abandons the run.
- R11: A start while a run is in progress is ignored. It does not re-assert phy_rst_o and does not add transactions.
- R12: A start in the finished state runs the complete sequence again, including the reset window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the bring-up sequence |
| stop_i | input | 1 | Abort and put the PHY back into reset |
| phy_rst_o | output | 1 | PHY reset, active high |
| cr_req_o | output | 1 | Bus transaction request |
| cr_we_o | output | 1 | 1 for a write, 0 for a read |
| cr_addr_o | output | 16 | Bus address |
| cr_wdata_o | output | 16 | Write data |
| cr_rdata_i | input | 16 | Read data, valid with cr_ack_i |
| cr_ack_i | input | 1 | Transaction completed |
| cr_err_i | input | 1 | Transaction failed |
| ctl0_o | output | 32 | Local control register (mode switch at bits 6:5) |
| cfg1_o | output | 32 | Local configuration register (loss-of-signal fields) |
| cfg2_o | output | 32 | Local configuration register (transmit boost field) |
| done_o | output | 1 | Sequence finished (with or without error) |
| err_o | output | 1 | Sequence ended by a bus error |

## Verification
The bus slave in the bench starts from non-trivial register contents, and the local registers start from non-zero values. A merge that lost bits outside the mask, or that dropped the out-of-mask value bit at 0x1010, therefore shows up as a wrong write value or a wrong register word. The reset window is measured in whole cycles, so a timer that is off by one, or a timer not cleared by a stop issued during the window, gives the wrong count on the next run. Errors are injected on both a read and a write: a design that kept going would make extra transactions or touch cfg1/cfg2. Stop, start during a run, and restart after completion are each exercised: a design that mishandled them would leave requests pending or re-pulse the reset.

// File: rtl/brup_pkg.sv
package brup_pkg;
  localparam int CR_AW     = 16;
  localparam int CR_DW     = 16;
  localparam int LREG_W    = 32;
  localparam int NUM_STEPS = 5;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  localparam int MODE_LSB  = 5;
  localparam int MODE_W    = 2;
  localparam int BOOST_LSB = 18;
  localparam int BOOST_W   = 3;
  localparam int BOOST_VAL = 4;
  localparam int LOSB_LSB  = 21;
  localparam int LOSB_W    = 3;
  localparam int LOSB_VAL  = 4;
  localparam int LOSL_LSB  = 16;
  localparam int LOSL_W    = 5;
  localparam int LOSL_VAL  = 9;

  typedef struct packed {
    logic [CR_AW-1:0] addr;
    logic [CR_DW-1:0] mask;
    logic [CR_DW-1:0] val;
  } step_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_MODE, S_RD, S_WR, S_BOOST, S_LOS, S_FIN
  } seq_state_e;

  function automatic step_t step_entry(input int idx);
    step_t s;
    case (idx)
      0:       s = '{addr: 16'h102D, mask: 16'h0080, val: 16'h0080};
      1:       s = '{addr: 16'h1010, mask: 16'h0FF0, val: 16'h0014};
      2:       s = '{addr: 16'h1006, mask: 16'h0FC0, val: 16'h0B80};
      3:       s = '{addr: 16'h1002, mask: 16'h7FFF, val: 16'h4B7F};
      default: s = '{addr: 16'h0030, mask: 16'h00F0, val: 16'h0080};
    endcase
    return s;
  endfunction

  function automatic logic [LREG_W-1:0] field_put(input logic [LREG_W-1:0] word,
                                                  input int lsb, input int w,
                                                  input int val);
    logic [LREG_W-1:0] m;
    m = ((LREG_W'(1) << w) - LREG_W'(1)) << lsb;
    return (word & ~m) | ((LREG_W'(val) << lsb) & m);
  endfunction
endpackage

// File: rtl/brup_rst_timer.sv
module brup_rst_timer #(
  parameter int CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic clear_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CNT_W'(CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/brup_step_rom.sv
module brup_step_rom
  import brup_pkg::*;
(
  input  logic [STEP_W-1:0] idx_i,
  output logic [CR_AW-1:0]  addr_o,
  output logic [CR_DW-1:0]  mask_o,
  output logic [CR_DW-1:0]  val_o
);
  step_t tbl [NUM_STEPS];

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_tbl
    assign tbl[g] = step_entry(g);
  end

  step_t sel;
  always_comb begin
    sel = tbl[NUM_STEPS-1];
    for (int i = 0; i < NUM_STEPS; i++) begin
      if (idx_i == STEP_W'(i)) sel = tbl[i];
    end
  end

  assign addr_o = sel.addr;
  assign mask_o = sel.mask;
  assign val_o  = sel.val;
endmodule

// File: rtl/brup_local_regs.sv
module brup_local_regs
  import brup_pkg::*;
#(
  parameter logic [LREG_W-1:0] CTL0_INIT = '0,
  parameter logic [LREG_W-1:0] CFG1_INIT = '0,
  parameter logic [LREG_W-1:0] CFG2_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_mode_i,
  input  logic              set_boost_i,
  input  logic              set_los_i,
  output logic [LREG_W-1:0] ctl0_o,
  output logic [LREG_W-1:0] cfg1_o,
  output logic [LREG_W-1:0] cfg2_o
);
  logic [LREG_W-1:0] ctl0_q, cfg1_q, cfg2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= CTL0_INIT;
      cfg1_q <= CFG1_INIT;
      cfg2_q <= CFG2_INIT;
    end else begin
      if (set_mode_i)
        ctl0_q <= field_put(ctl0_q, MODE_LSB, MODE_W, (1 << MODE_W) - 1);
      if (set_boost_i)
        cfg2_q <= field_put(cfg2_q, BOOST_LSB, BOOST_W, BOOST_VAL);
      if (set_los_i)
        cfg1_q <= field_put(field_put(cfg1_q, LOSB_LSB, LOSB_W, LOSB_VAL),
                            LOSL_LSB, LOSL_W, LOSL_VAL);
    end
  end

  assign ctl0_o = ctl0_q;
  assign cfg1_o = cfg1_q;
  assign cfg2_o = cfg2_q;
endmodule

// File: rtl/brup_phy_cfg_seq.sv
module brup_phy_cfg_seq
  import brup_pkg::*;
#(
  parameter int                RST_CYCLES = 50,
  parameter logic [LREG_W-1:0] CTL0_INIT  = '0,
  parameter logic [LREG_W-1:0] CFG1_INIT  = '0,
  parameter logic [LREG_W-1:0] CFG2_INIT  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              phy_rst_o,
  output logic              cr_req_o,
  output logic              cr_we_o,
  output logic [CR_AW-1:0]  cr_addr_o,
  output logic [CR_DW-1:0]  cr_wdata_o,
  input  logic [CR_DW-1:0]  cr_rdata_i,
  input  logic              cr_ack_i,
  input  logic              cr_err_i,
  output logic [LREG_W-1:0] ctl0_o,
  output logic [LREG_W-1:0] cfg1_o,
  output logic [LREG_W-1:0] cfg2_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [CR_DW-1:0]  rd_q;
  logic              rst_q, done_q, err_q;

  logic              start_ok, tmr_busy, tmr_expire;
  logic [CR_AW-1:0]  st_addr;
  logic [CR_DW-1:0]  st_mask, st_val;
  logic              in_bus;

  assign start_ok = start_i && !stop_i && (state_q == S_IDLE || state_q == S_FIN);
  assign in_bus   = (state_q == S_RD) || (state_q == S_WR);

  brup_rst_timer #(.CYCLES(RST_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_ok),
    .clear_i  (stop_i),
    .busy_o   (tmr_busy),
    .expire_o (tmr_expire)
  );

  brup_step_rom u_rom (
    .idx_i  (step_q),
    .addr_o (st_addr),
    .mask_o (st_mask),
    .val_o  (st_val)
  );

  brup_local_regs #(
    .CTL0_INIT (CTL0_INIT),
    .CFG1_INIT (CFG1_INIT),
    .CFG2_INIT (CFG2_INIT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_mode_i  (state_q == S_MODE  && !stop_i),
    .set_boost_i (state_q == S_BOOST && !stop_i),
    .set_los_i   (state_q == S_LOS   && !stop_i),
    .ctl0_o      (ctl0_o),
    .cfg1_o      (cfg1_o),
    .cfg2_o      (cfg2_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      rd_q    <= '0;
      rst_q   <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      rst_q   <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE, S_FIN: begin
          if (start_ok) begin
            state_q <= S_RST;
            step_q  <= '0;
            rst_q   <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        S_RST: begin
          if (tmr_expire || !tmr_busy) begin
            rst_q   <= 1'b0;
            state_q <= S_MODE;
          end
        end
        S_MODE: state_q <= S_RD;
        S_RD: begin
          if (cr_err_i) begin
            state_q <= S_FIN;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else if (cr_ack_i) begin
            rd_q    <= cr_rdata_i;
            state_q <= S_WR;
          end
        end
        S_WR: begin
          if (cr_err_i) begin
            state_q <= S_FIN;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
          end else if (cr_ack_i) begin
            if (step_q == STEP_W'(NUM_STEPS - 1)) begin
              state_q <= S_BOOST;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= S_RD;
            end
          end
        end
        S_BOOST: state_q <= S_LOS;
        S_LOS: begin
          state_q <= S_FIN;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign phy_rst_o  = rst_q;
  assign cr_req_o   = in_bus;
  assign cr_we_o    = (state_q == S_WR);
  assign cr_addr_o  = st_addr;
  assign cr_wdata_o = (rd_q & ~st_mask) | st_val;
  assign done_o     = done_q;
  assign err_o      = err_q;
endmodule

// File: rtl/brup_phy_cfg_seq_chk.sv
module brup_phy_cfg_seq_chk
  import brup_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              phy_rst_o,
  input logic              cr_req_o,
  input logic              cr_we_o,
  input logic [CR_AW-1:0]  cr_addr_o,
  input logic [CR_DW-1:0]  cr_wdata_o,
  input logic              cr_ack_i,
  input logic              cr_err_i,
  input logic [LREG_W-1:0] ctl0_o,
  input logic [LREG_W-1:0] cfg1_o,
  input logic [LREG_W-1:0] cfg2_o,
  input logic              done_o,
  input logic              err_o
);
  AST_NO_REQ_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_req_o |-> !phy_rst_o); // R2
  AST_MODE_BEFORE_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_req_o |-> ctl0_o[6:5] == 2'b11); // R3
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_req_o && !cr_ack_i && !cr_err_i && !stop_i) |=>
      (cr_req_o && $stable(cr_addr_o) && $stable(cr_we_o) && $stable(cr_wdata_o))); // R6
  AST_LOCAL_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && !err_o) |->
      (cfg2_o[20:18] == 3'd4 && cfg1_o[23:21] == 3'd4 && cfg1_o[20:16] == 5'd9)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cr_req_o); // R8
  AST_ERR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R9
  AST_STOP_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (phy_rst_o && !cr_req_o && !done_o && !err_o)); // R10
endmodule

bind brup_phy_cfg_seq brup_phy_cfg_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .phy_rst_o  (phy_rst_o),
  .cr_req_o   (cr_req_o),
  .cr_we_o    (cr_we_o),
  .cr_addr_o  (cr_addr_o),
  .cr_wdata_o (cr_wdata_o),
  .cr_ack_i   (cr_ack_i),
  .cr_err_i   (cr_err_i),
  .ctl0_o     (ctl0_o),
  .cfg1_o     (cfg1_o),
  .cfg2_o     (cfg2_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/brup_phy_cfg_seq_tb.sv
module brup_phy_cfg_seq_tb;
  localparam int RSTC = 50;
  localparam logic [31:0] C0 = 32'h8000_0011;
  localparam logic [31:0] C1 = 32'hFFFF_FFFF;
  localparam logic [31:0] C2 = 32'h1234_5678;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic        phy_rst, req, we, done, err;
  logic [15:0] addr, wdata;
  logic [15:0] rdata = '0;
  logic        ack = 1'b0, berr = 1'b0;
  logic [31:0] ctl0, cfg1, cfg2;

  brup_phy_cfg_seq #(
    .RST_CYCLES(RSTC), .CTL0_INIT(C0), .CFG1_INIT(C1), .CFG2_INIT(C2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .phy_rst_o(phy_rst), .cr_req_o(req), .cr_we_o(we), .cr_addr_o(addr),
    .cr_wdata_o(wdata), .cr_rdata_i(rdata), .cr_ack_i(ack), .cr_err_i(berr),
    .ctl0_o(ctl0), .cfg1_o(cfg1), .cfg2_o(cfg2), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  // model of the step list (R5)
  function automatic logic [15:0] m_addr(input int s);
    case (s) 0: return 16'h102D; 1: return 16'h1010; 2: return 16'h1006;
             3: return 16'h1002; default: return 16'h0030; endcase
  endfunction
  function automatic logic [15:0] m_mask(input int s);
    case (s) 0: return 16'h0080; 1: return 16'h0FF0; 2: return 16'h0FC0;
             3: return 16'h7FFF; default: return 16'h00F0; endcase
  endfunction
  function automatic logic [15:0] m_val(input int s);
    case (s) 0: return 16'h0080; 1: return 16'h0014; 2: return 16'h0B80;
             3: return 16'h4B7F; default: return 16'h0080; endcase
  endfunction

  logic [15:0] mem [int];
  int lat = 0, err_at = -1, txn = 0, wait_cnt = 0;

  // bus slave and per-clock monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 0; berr = 0; wait_cnt = 0;
    end else begin
      if (req) chk(!phy_rst, "R2 req while phy reset", 32'(phy_rst), 0);
      if (ack || berr) begin
        ack = 0; berr = 0; wait_cnt = 0;
      end else if (req) begin
        if (wait_cnt >= lat) begin
          int s;
          logic [15:0] a;
          s = (txn / 2) % 5;
          a = m_addr(s);
          chk(addr == a, "R5 address", 32'(addr), 32'(a));
          chk(we == 1'(txn % 2), "R4 direction", 32'(we), 32'(txn % 2));
          if (txn == err_at) begin
            berr = 1;
          end else if (!we) begin
            rdata = mem[addr];
            ack = 1;
          end else begin
            logic [15:0] e;
            e = (mem[addr] & ~m_mask(s)) | m_val(s);
            chk(wdata == e, "R4 merged write", 32'(wdata), 32'(e));
            mem[addr] = wdata;
            ack = 1;
          end
          txn++;
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  function automatic logic [31:0] put(input logic [31:0] w, input int lsb, input int wd, input int v);
    logic [31:0] m;
    m = ((32'd1 << wd) - 1) << lsb;
    return (w & ~m) | ((32'(v) << lsb) & m);
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run(input int l, input int ea, output int rc);
    int k;
    lat = l; err_at = ea; txn = 0;
    pulse_start();
    rc = 0;
    while (phy_rst && rc < 1000) begin rc++; @(negedge clk); end
    k = 0;
    while (!done && k < 5000) begin k++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rc;
    logic [31:0] e1, e2;
    mem[16'h102D] = 16'h1234; mem[16'h1010] = 16'hABCD; mem[16'h1006] = 16'hFFFF;
    mem[16'h1002] = 16'h8000; mem[16'h0030] = 16'h5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(phy_rst == 1, "R1 phy_rst", 32'(phy_rst), 1);
    chk(!req && !done && !err, "R1 req/done/err", {req, done, err}, 0);
    chk(ctl0 == C0 && cfg1 == C1 && cfg2 == C2, "R1 local regs", cfg2, C2);

    // error on a write transaction
    run(1, 3, rc);
    chk(rc == RSTC, "R2 reset window", rc, RSTC);
    chk(done && err, "R9 done+err", {done, err}, 3);
    chk(txn == 4, "R9 transactions stop", txn, 4);
    chk(cfg1 == C1 && cfg2 == C2, "R9 cfg untouched", cfg1, C1);
    e1 = put(C0, 5, 2, 3);
    chk(ctl0 == e1, "R3 mode bits", ctl0, e1);
    repeat (5) @(negedge clk);
    chk(txn == 4 && !req, "R9 bus quiet", txn, 4);

    // error on a read transaction
    run(0, 0, rc);
    chk(done && err && txn == 1, "R9 read error", txn, 1);

    // full runs, zero and multi-cycle latency
    run(0, -1, rc);
    chk(rc == RSTC, "R2 reset window", rc, RSTC);
    chk(done && !err, "R8 done clean", {done, err}, 2);
    chk(txn == 10, "R5 transaction count", txn, 10);
    e2 = put(C2, 18, 3, 4);
    e1 = put(put(C1, 21, 3, 4), 16, 5, 9);
    chk(cfg2 == e2, "R7 boost field", cfg2, e2);
    chk(cfg1 == e1, "R7 los fields", cfg1, e1);
    repeat (10) @(negedge clk);
    chk(done && !err && !req, "R8 holds", {done, err, req}, 4);

    // restart after done with slow bus
    run(3, -1, rc);
    chk(rc == RSTC, "R12 reset window again", rc, RSTC);
    chk(done && !err && txn == 10, "R12 rerun", txn, 10);

    // stop during reset window, then a clean run
    pulse_start();
    repeat (5) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    chk(phy_rst && !req && !done && !err, "R10 stop in window", {phy_rst, req, done, err}, 8);
    run(0, -1, rc);
    chk(rc == RSTC, "R10 timer cleared by stop", rc, RSTC);

    // stop mid-sequence
    lat = 2; err_at = -1; txn = 0;
    pulse_start();
    while (txn < 3) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    chk(phy_rst && !req && !done && !err, "R10 stop mid run", {phy_rst, req, done, err}, 8);
    repeat (10) @(negedge clk);
    chk(!req && txn <= 4, "R10 abandoned", txn, 4);

    // start during a run is ignored
    lat = 1; txn = 0;
    pulse_start();
    while (txn < 4) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    chk(!phy_rst, "R11 no reset re-pulse", 32'(phy_rst), 0);
    begin
      int k = 0;
      while (!done && k < 5000) begin k++; @(negedge clk); end
    end
    chk(done && !err && txn == 10, "R11 no extra transactions", txn, 10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule